// File: doc/BRIEF.md
# Execute Stage with Local Forwarding

This block is the execute step of an in-order integer pipeline. It takes decoded instructions over a valid/ready channel and runs them through a small ALU (add, subtract, and, or, unsigned set-less-than). It hands the result, the destination register, the memory controls and the store data to the memory step over a second valid/ready channel. A third input carries load results back from writeback. Each load result is tagged with the register it targets.

All hazard handling lives inside the stage. A short history of the stage's own recent results stands in for register-file values that decode read before they were written back. A history entry created by a load has no data yet. It is filled in later when writeback returns the load value. An instruction that needs such a value waits at the input channel until the value arrives. No other stage takes part in this, and no hazard state is exchanged with other stages.

Top module: `ex_fwd_stage`

## Requirements
- R1: Opcode 0 adds, 1 subtracts (operand A minus operand B), 2 is bitwise and, 3 is bitwise or. All arithmetic wraps modulo 2^32 and never traps.
- R2: Opcode 4 produces 1 when operand A is below operand B as unsigned numbers, and 0 otherwise.
- R3: Operand A is the Rs value. Operand B is the immediate when the immediate-select control is 1, and the Rt value otherwise.
- R4: The destination register is Rd when the destination-select control is 1, and Rt otherwise.
- R5: A source register that equals the destination of a register-writing entry among the last two executed instructions takes that entry's result instead of the decode operand. Entries with register-write 0, and instructions three or more back, are not used.
- R6: When both history entries match a source, the more recent entry supplies the value.
- R7: Source register 0 always reads as zero, whatever decode supplies or the history holds.
- R8: If a used source matches a load entry whose data has not arrived, the input ready is low and no result is produced. A load result that arrives in the same cycle releases the stall. Rt counts as used when the immediate-select is 0 or the store control is 1.
- R9: A load result updates the most recent pending load entry with the same register, and later instructions then forward that data. A load result that matches no pending load entry changes nothing.
- R10: The register-write, memory-read, memory-write and mem-to-reg controls pass unchanged to the output. The store data output is the forwarded Rt value.
- R11: An output held with output ready low stays valid and unchanged. The input ready stays low while that output is undrained.
- R12: After reset the output is not valid, the history is empty, and an instruction with no dependency is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_ready_o | output | 1 | Stage accepts the instruction this cycle |
| in_op_i | input | 3 | ALU opcode (see R1, R2) |
| in_rs_i | input | 5 | Rs register number |
| in_rt_i | input | 5 | Rt register number |
| in_rd_i | input | 5 | Rd register number |
| in_rs_val_i | input | 32 | Rs value read by decode |
| in_rt_val_i | input | 32 | Rt value read by decode |
| in_imm_i | input | 32 | Sign-extended immediate |
| in_use_imm_i | input | 1 | Operand B is the immediate |
| in_dst_rd_i | input | 1 | Destination is Rd, not Rt |
| in_reg_wr_i | input | 1 | Instruction writes a register |
| in_mem_rd_i | input | 1 | Instruction is a load |
| in_mem_wr_i | input | 1 | Instruction is a store |
| in_mem_to_reg_i | input | 1 | Writeback takes memory data |
| ld_valid_i | input | 1 | Load result from writeback present |
| ld_reg_i | input | 5 | Register the load result targets |
| ld_data_i | input | 32 | Load result |
| out_valid_o | output | 1 | Result present for the memory step |
| out_ready_i | input | 1 | Memory step takes the result |
| out_result_o | output | 32 | ALU result or address |
| out_dst_o | output | 5 | Destination register |
| out_reg_wr_o | output | 1 | Passed register-write control |
| out_mem_rd_o | output | 1 | Passed memory-read control |
| out_mem_wr_o | output | 1 | Passed memory-write control |
| out_mem_to_reg_o | output | 1 | Passed mem-to-reg control |
| out_store_o | output | 32 | Store data (forwarded Rt) |

## Verification
The bench builds the stage with the default history depth of two. With that depth it can reach three distinct cases: forwarding from the newest entry, forwarding from the oldest entry, and the fall-back to the decode value one instruction after an entry is evicted. The same depth lets a load entry survive one further instruction. This means a stall on Rs, a stall on the store-data Rt, a same-cycle release, and late forwarding of a filled entry can all be driven in short sequences with stale decode operands that expose any missing bypass.

// File: rtl/ex_fwd_pkg.sv
package ex_fwd_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic              ld;
    logic              rdy;
    logic [REG_W-1:0]  rd;
    logic [DATA_W-1:0] data;
  } hist_ent_t;
endpackage

// File: rtl/ex_fwd_alu.sv
module ex_fwd_alu
  import ex_fwd_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(DATA_W-1){1'b0}}, (a_i < b_i)};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/ex_fwd_history.sv
module ex_fwd_history
  import ex_fwd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_valid_i,
  input  logic [REG_W-1:0]        ld_reg_i,
  input  logic [DATA_W-1:0]       ld_data_i,
  input  logic                    push_i,
  input  hist_ent_t               push_ent_i,
  output hist_ent_t [DEPTH-1:0]   view_o,
  output logic                    pend_any_o
);
  hist_ent_t [DEPTH-1:0] hist_q;

  // view = stored entries with this cycle's load result merged in (index 0 newest)
  always_comb begin
    logic claimed;
    claimed = 1'b0;
    view_o  = hist_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (!claimed && ld_valid_i && hist_q[i].valid && hist_q[i].ld &&
          !hist_q[i].rdy && hist_q[i].rd == ld_reg_i) begin
        view_o[i].rdy  = 1'b1;
        view_o[i].data = ld_data_i;
        claimed        = 1'b1;
      end
    end
  end

  always_comb begin
    pend_any_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (view_o[i].valid && view_o[i].wr && view_o[i].ld && !view_o[i].rdy)
        pend_any_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (push_i) begin
      hist_q[0] <= push_ent_i;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= view_o[i-1];
    end else begin
      hist_q <= view_o;
    end
  end

  // R5: entries from ALU-only instructions carry data from the start
  assert_alu_entry_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_q[0].valid && !hist_q[0].ld |-> hist_q[0].rdy);

  // R9: a pending newest entry stays pending without a matching load result
  assert_pending_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && hist_q[0].valid && hist_q[0].ld && !hist_q[0].rdy &&
    !(ld_valid_i && ld_reg_i == hist_q[0].rd) |=> !hist_q[0].rdy);
endmodule

// File: rtl/ex_fwd_select.sv
module ex_fwd_select
  import ex_fwd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic [REG_W-1:0]       src_i,
  input  logic [DATA_W-1:0]      dec_val_i,
  input  hist_ent_t [DEPTH-1:0]  view_i,
  output logic [DATA_W-1:0]      val_o,
  output logic                   pend_o
);
  always_comb begin
    logic hit;
    hit    = 1'b0;
    pend_o = 1'b0;
    val_o  = dec_val_i;
    // oldest first so the newest match overwrites
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (view_i[i].valid && view_i[i].wr && view_i[i].rd == src_i) begin
        hit    = 1'b1;
        val_o  = view_i[i].data;
        pend_o = view_i[i].ld && !view_i[i].rdy;
      end
    end
    if (src_i == '0) begin
      val_o  = '0;
      pend_o = 1'b0;
    end
  end
endmodule

// File: rtl/ex_fwd_stage.sv
module ex_fwd_stage
  import ex_fwd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        in_op_i,
  input  logic [4:0]        in_rs_i,
  input  logic [4:0]        in_rt_i,
  input  logic [4:0]        in_rd_i,
  input  logic [31:0]       in_rs_val_i,
  input  logic [31:0]       in_rt_val_i,
  input  logic [31:0]       in_imm_i,
  input  logic              in_use_imm_i,
  input  logic              in_dst_rd_i,
  input  logic              in_reg_wr_i,
  input  logic              in_mem_rd_i,
  input  logic              in_mem_wr_i,
  input  logic              in_mem_to_reg_i,
  input  logic              ld_valid_i,
  input  logic [4:0]        ld_reg_i,
  input  logic [31:0]       ld_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [31:0]       out_result_o,
  output logic [4:0]        out_dst_o,
  output logic              out_reg_wr_o,
  output logic              out_mem_rd_o,
  output logic              out_mem_wr_o,
  output logic              out_mem_to_reg_o,
  output logic [31:0]       out_store_o
);
  localparam int NSRC = 2;

  hist_ent_t [DEPTH-1:0] view;
  hist_ent_t             push_ent;
  logic                  pend_any;

  logic [REG_W-1:0]  src      [NSRC];
  logic [DATA_W-1:0] dec_val  [NSRC];
  logic [DATA_W-1:0] fwd_val  [NSRC];
  logic              src_pend [NSRC];

  logic [DATA_W-1:0] opb, alu_res;
  logic [REG_W-1:0]  dst;
  logic              rt_used, stall, out_space, fire;

  assign src[0]     = in_rs_i;
  assign src[1]     = in_rt_i;
  assign dec_val[0] = in_rs_val_i;
  assign dec_val[1] = in_rt_val_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ex_fwd_select #(.DEPTH(DEPTH)) u_sel (
      .src_i     (src[g]),
      .dec_val_i (dec_val[g]),
      .view_i    (view),
      .val_o     (fwd_val[g]),
      .pend_o    (src_pend[g])
    );
  end

  assign rt_used   = !in_use_imm_i || in_mem_wr_i;
  assign stall     = src_pend[0] || (src_pend[1] && rt_used);
  assign out_space = !out_valid_o || out_ready_i;
  assign in_ready_o = out_space && !stall;
  assign fire      = in_valid_i && in_ready_o;

  assign opb = in_use_imm_i ? in_imm_i : fwd_val[1];
  assign dst = in_dst_rd_i ? in_rd_i : in_rt_i;

  ex_fwd_alu u_alu (
    .op_i  (in_op_i),
    .a_i   (fwd_val[0]),
    .b_i   (opb),
    .res_o (alu_res)
  );

  always_comb begin
    push_ent       = '0;
    push_ent.valid = 1'b1;
    push_ent.wr    = in_reg_wr_i;
    push_ent.ld    = in_mem_rd_i;
    push_ent.rdy   = !in_mem_rd_i;
    push_ent.rd    = dst;
    push_ent.data  = in_mem_rd_i ? '0 : alu_res;
  end

  ex_fwd_history #(.DEPTH(DEPTH)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid_i),
    .ld_reg_i   (ld_reg_i),
    .ld_data_i  (ld_data_i),
    .push_i     (fire),
    .push_ent_i (push_ent),
    .view_o     (view),
    .pend_any_o (pend_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o      <= 1'b0;
      out_result_o     <= '0;
      out_dst_o        <= '0;
      out_reg_wr_o     <= 1'b0;
      out_mem_rd_o     <= 1'b0;
      out_mem_wr_o     <= 1'b0;
      out_mem_to_reg_o <= 1'b0;
      out_store_o      <= '0;
    end else if (fire) begin
      out_valid_o      <= 1'b1;
      out_result_o     <= alu_res;
      out_dst_o        <= dst;
      out_reg_wr_o     <= in_reg_wr_i;
      out_mem_rd_o     <= in_mem_rd_i;
      out_mem_wr_o     <= in_mem_wr_i;
      out_mem_to_reg_o <= in_mem_to_reg_i;
      out_store_o      <= fwd_val[1];
    end else if (out_ready_i) begin
      out_valid_o      <= 1'b0;
    end
  end

  assert_out_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_result_o) && $stable(out_dst_o));

  assert_accept_emits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R8: a refusal with room downstream needs an outstanding load in the history
  assert_stall_has_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !in_ready_o && out_space |-> pend_any);

  assert_rise_from_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i));
endmodule

// File: tb/ex_fwd_stage_tb_top.sv
module ex_fwd_stage_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic in_valid_i = 0, in_ready_o;
  logic [2:0] in_op_i = 0;
  logic [4:0] in_rs_i = 0, in_rt_i = 0, in_rd_i = 0;
  logic [31:0] in_rs_val_i = 0, in_rt_val_i = 0, in_imm_i = 0;
  logic in_use_imm_i = 0, in_dst_rd_i = 0, in_reg_wr_i = 0;
  logic in_mem_rd_i = 0, in_mem_wr_i = 0, in_mem_to_reg_i = 0;
  logic ld_valid_i = 0;
  logic [4:0] ld_reg_i = 0;
  logic [31:0] ld_data_i = 0;
  logic out_valid_o, out_ready_i = 1;
  logic [31:0] out_result_o, out_store_o;
  logic [4:0] out_dst_o;
  logic out_reg_wr_o, out_mem_rd_o, out_mem_wr_o, out_mem_to_reg_o;

  ex_fwd_stage dut_i (.*);

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    logic [31:0] store;
    logic [3:0]  ctrl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, n_out = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: transfer happens at the next posedge when both are high
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(0, "R1 unexpected output", out_result_o, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_result_o == e.res, {e.tag, " result"}, out_result_o, e.res);
        chk(out_dst_o == e.dst, {e.tag, " R4 dst"}, 32'(out_dst_o), 32'(e.dst));
        chk(out_store_o == e.store, {e.tag, " R10 store"}, out_store_o, e.store);
        chk({out_reg_wr_o, out_mem_rd_o, out_mem_wr_o, out_mem_to_reg_o} == e.ctrl,
            {e.tag, " R10 ctrl"},
            32'({out_reg_wr_o, out_mem_rd_o, out_mem_wr_o, out_mem_to_reg_o}), 32'(e.ctrl));
      end
      n_out++;
    end
  end

  // driver: called just after a posedge, returns just after the accepting posedge
  task automatic send(input logic [2:0] op, input int rs, input int rt, input int rd,
                      input logic [31:0] rsv, input logic [31:0] rtv, input logic [31:0] imm,
                      input logic ai, input logic drd, input logic wr, input logic mr,
                      input logic mw, input logic m2r,
                      input logic [31:0] er, input int ed, input logic [31:0] es,
                      input string tag);
    exp_t e;
    in_op_i = op; in_rs_i = 5'(rs); in_rt_i = 5'(rt); in_rd_i = 5'(rd);
    in_rs_val_i = rsv; in_rt_val_i = rtv; in_imm_i = imm;
    in_use_imm_i = ai; in_dst_rd_i = drd; in_reg_wr_i = wr;
    in_mem_rd_i = mr; in_mem_wr_i = mw; in_mem_to_reg_i = m2r;
    in_valid_i = 1'b1;
    forever begin
      @(negedge clk_i);
      if (in_ready_o) break;
    end
    e.res = er; e.dst = 5'(ed); e.store = es; e.ctrl = {wr, mr, mw, m2r}; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
  endtask

  task automatic alu(input logic [2:0] op, input int rs, input int rt, input int rd,
                     input logic [31:0] rsv, input logic [31:0] rtv,
                     input logic [31:0] er, input string tag);
    send(op, rs, rt, rd, rsv, rtv, 0, 0, 1, 1, 0, 0, 0, er, rd, er == er ? 32'h0 : 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int n0;
    logic [31:0] held;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 0, "R12 reset out_valid", 32'(out_valid_o), 0);
    chk(in_ready_o == 1, "R12 reset ready", 32'(in_ready_o), 1);
    @(posedge clk_i); #1;

    // store data expected equals forwarded Rt; for these Rt is not in history
    send(0, 1, 2, 10, 32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0,1,1,0,0,0, 32'hFFFFFFFF, 10, 32'h5A5A5A5A, "R1 add");
    send(1, 3, 4, 17, 32'hA5A5A5A5, 32'h5A5A5A5A, 0, 0,1,1,0,0,0, 32'h4B4B4B4B, 17, 32'h5A5A5A5A, "R1 sub");
    send(2, 5, 6, 31, 32'hA5A5A5A5, 32'h5AFF5AFF, 0, 0,1,1,0,0,0, 32'h00A500A5, 31, 32'h5AFF5AFF, "R1 and");
    send(3, 7, 9, 5,  32'hA5A5A5A5, 32'h5A005A00, 0, 0,1,1,0,0,0, 32'hFFA5FFA5, 5,  32'h5A005A00, "R1 or");
    send(4, 11, 12, 13, 32'h05A5A5A5, 32'h5A005A00, 0, 0,1,1,0,0,0, 1, 13, 32'h5A005A00, "R2 slt less");
    send(4, 11, 12, 14, 32'h05A5A5A5, 32'h05A5A5A5, 0, 0,1,1,0,0,0, 0, 14, 32'h05A5A5A5, "R2 slt equal");
    send(4, 11, 12, 15, 32'h80000000, 32'h00000001, 0, 0,1,1,0,0,0, 0, 15, 32'h1, "R2 slt unsigned");
    send(0, 11, 12, 16, 32'hFFFFFFFF, 32'h2, 0, 0,1,1,0,0,0, 1, 16, 32'h2, "R1 add wrap");
    send(1, 11, 12, 18, 32'h0, 32'h1, 0, 0,1,1,0,0,0, 32'hFFFFFFFF, 18, 32'h1, "R1 sub wrap");
    // H=[r18,r16]
    send(0, 20, 5, 9, 32'hA5A5A5A5, 32'h12345678, 32'h25252525, 1,0,1,0,0,0, 32'hCACACACA, 5, 32'h12345678, "R3 imm");
    send(0, 20, 21, 22, 32'h1, 32'h2, 0, 0,0,1,0,0,0, 32'h3, 21, 32'h2, "R4 dst rt");
    // H=[r21=3, r5]
    send(0, 21, 20, 23, 32'h0, 32'd10, 0, 0,1,1,0,0,0, 32'd13, 23, 32'd10, "R5 newest");
    send(0, 21, 24, 25, 32'h0, 32'd1, 0, 0,1,1,0,0,0, 32'd4, 25, 32'd1, "R5 older");
    send(0, 21, 24, 26, 32'd100, 32'd1, 0, 0,1,1,0,0,0, 32'd101, 26, 32'd1, "R5 evicted");
    send(0, 20, 24, 27, 32'd5, 32'd5, 0, 0,1,0,0,0,0, 32'd10, 27, 32'd5, "R5 nonwrite");
    send(0, 27, 24, 28, 32'd7, 32'd1, 0, 0,1,1,0,0,0, 32'd8, 28, 32'd1, "R5 nonwrite ignored");
    send(0, 20, 24, 29, 32'd1, 32'd1, 0, 0,1,1,0,0,0, 32'd2, 29, 32'd1, "R6 first");
    send(0, 20, 24, 29, 32'd5, 32'd5, 0, 0,1,1,0,0,0, 32'd10, 29, 32'd5, "R6 second");
    send(0, 29, 24, 30, 32'd0, 32'd0, 0, 0,1,1,0,0,0, 32'd10, 30, 32'd0, "R6 newer wins");
    send(0, 20, 24, 0, 32'd7, 32'd1, 0, 0,1,1,0,0,0, 32'd8, 0, 32'd1, "R7 write r0");
    send(0, 0, 0, 1, 32'd55, 32'd66, 0, 0,1,1,0,0,0, 32'd0, 1, 32'd0, "R7 r0 zero");
    // H=[r1=0, r0]
    send(0, 30, 1, 2, 32'h100, 32'd77, 32'd4, 1,0,0,0,1,0, 32'h104, 1, 32'd0, "R10 store");
    // load then dependent on Rs
    send(0, 2, 8, 0, 32'h200, 32'd0, 32'd8, 1,0,1,1,0,1, 32'h208, 8, 32'd0, "R8 load");
    fork
      send(0, 8, 3, 9, 32'd0, 32'd5, 0, 0,1,1,0,0,0, 32'h1005, 9, 32'd5, "R8 rs after load");
      begin
        repeat (2) @(negedge clk_i);
        #1 n0 = n_out;
        repeat (2) @(negedge clk_i);
        #1;
        chk(in_ready_o == 0, "R8 stall ready low", 32'(in_ready_o), 0);
        chk(n_out == n0, "R8 no output in stall", 32'(n_out), 32'(n0));
        @(posedge clk_i); #1;
        ld_valid_i = 1; ld_reg_i = 8; ld_data_i = 32'h1000;
        @(posedge clk_i); #1;
        ld_valid_i = 0;
      end
    join
    send(0, 3, 8, 10, 32'd1, 32'd0, 0, 0,1,1,0,0,0, 32'h1001, 10, 32'h1000, "R9 filled entry");
    // load result with no pending entry
    ld_valid_i = 1; ld_reg_i = 10; ld_data_i = 32'hBAD;
    @(posedge clk_i); #1;
    ld_valid_i = 0;
    send(0, 10, 24, 11, 32'd0, 32'd0, 0, 0,1,1,0,0,0, 32'h1001, 11, 32'd0, "R9 stray load ignored");
    // load result arrives before dependent is presented
    send(0, 2, 12, 0, 32'h10, 32'd0, 32'd0, 1,0,1,1,0,1, 32'h10, 12, 32'd0, "R9 load2");
    ld_valid_i = 1; ld_reg_i = 12; ld_data_i = 32'h777;
    @(posedge clk_i); #1;
    ld_valid_i = 0;
    send(0, 12, 24, 13, 32'd0, 32'd0, 0, 0,1,1,0,0,0, 32'h777, 13, 32'd0, "R9 early load");
    // store data stall on Rt with immediate operand
    send(0, 2, 14, 0, 32'h20, 32'd0, 32'd0, 1,0,1,1,0,1, 32'h20, 14, 32'd0, "R8 load3");
    fork
      send(0, 20, 14, 0, 32'h40, 32'd0, 32'd0, 1,0,0,0,1,0, 32'h40, 14, 32'hABC, "R8 rt store stall");
      begin
        repeat (3) @(negedge clk_i);
        #1 chk(in_ready_o == 0, "R8 rt stall ready low", 32'(in_ready_o), 0);
        @(posedge clk_i); #1;
        ld_valid_i = 1; ld_reg_i = 14; ld_data_i = 32'hABC;
        #1 chk(in_ready_o == 1, "R8 same-cycle release", 32'(in_ready_o), 1);
        @(posedge clk_i); #1;
        ld_valid_i = 0;
      end
    join
    // backpressure
    repeat (2) @(posedge clk_i); #1;
    out_ready_i = 0;
    send(3, 20, 24, 15, 32'hF0, 32'h0F, 0, 0,1,1,0,0,0, 32'hFF, 15, 32'h0F, "R11 held");
    fork
      send(0, 20, 24, 16, 32'd1, 32'd2, 0, 0,1,1,0,0,0, 32'd3, 16, 32'd2, "R11 after");
      begin
        @(negedge clk_i); #1 held = out_result_o;
        repeat (2) @(negedge clk_i);
        #1;
        chk(in_ready_o == 0, "R11 ready low when full", 32'(in_ready_o), 0);
        chk(out_valid_o == 1 && out_result_o == held, "R11 output held", out_result_o, held);
        @(posedge clk_i); #1 out_ready_i = 1;
      end
    join
    repeat (5) @(posedge clk_i);
    chk(exp_q.size() == 0, "R11 all outputs drained", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule